// File: doc/BRIEF.md
# Multi-CPU Interrupt Distributor

This block collects interrupt sources for a small cluster of processors, holds a state record for every interrupt, and presents each processor with the one interrupt it should service next. Interrupt numbers fall into three classes. Numbers 0 to 15 are raised by software. Numbers 16 to 31 are private per-processor peripheral lines. Numbers 32 and up are shared peripheral lines that are routed by a per-interrupt processor mask. Every interrupt carries an enable flag, a pending flag, an active flag, an 8-bit priority and a trigger-mode flag. The private classes are banked, so each processor owns its own copy of interrupts 0 to 31.

Software programs the block through a word-wide register port. The register address carries a requesting-processor number, which selects the private bank. The enable, pending and active flags each have a set view and a clear view. A dedicated command raises a software interrupt in one of three targeting modes. Each processor port shows a valid flag, an interrupt number and a priority. A one-cycle acknowledge pulse on that port moves the shown interrupt from pending to active. Software ends the active state through the active-clear view.

Top module: `irq_dist_top`

## Requirements
- R1: After synchronous reset, every processor port shows valid 0, all enable, pending and active flags are 0, all priorities and target masks are 0, every trigger-mode flag reads 1 (edge), and read data is 0.
- R2: An interrupt whose enable flag is 0 is never shown on any processor port. Its pending flag is kept while it is disabled.
- R3: Numbers 0..31 are banked per processor and are shown only to their own processor. Number 16+k of processor c is driven by line ppi_line[16*c+k]. Number 32+j is driven by spi_line[j] and is shown to processor c only while bit c of its target mask is 1. A target write to a number below 32 is ignored, and such a target reads as 0.
- R4: Each processor is shown the eligible interrupt with the numerically lowest priority value. When priorities are equal, the lower interrupt number wins.
- R5: reg_addr[13:10] selects a function and reg_addr[9:0] an index: 0/1 enable set/clear, 2/3 pending set/clear, 4/5 active set/clear, 6 priority, 7 target mask, 8 trigger mode, 9 software interrupt. For functions 0..5 the index is word n, covering numbers 32n..32n+31 on data bits 0..31. Word 0 is the bank of requester reg_cpu. Writing a 1 sets or clears the flag, writing 0 leaves it unchanged, and reading either view of a pair returns the flag.
- R6: In edge mode (trigger flag 1) a rising edge of the line sets pending. Pending then stays set after the line falls, until an acknowledge or a pending-clear write.
- R7: In level mode (trigger flag 0) pending follows the line on every cycle in which the interrupt is not active. Numbers 0..15 have no line, ignore trigger-mode writes, and always read edge mode.
- R8: A function-9 write raises number wdata[3:0] in the banks selected by wdata[25:24]. Mode 0 selects the processors whose bits are set in wdata[15:8]. Mode 1 selects every processor except reg_cpu. Mode 2 selects reg_cpu only. Mode 3 selects none.
- R9: A write whose interrupt number, or bit-view word, lies at or above NUM_IRQ changes no state. It does not alias onto an implemented number.
- R10: Only an interrupt that is enabled, pending and not active is shown. An acknowledge while valid is 1 clears pending and sets active for the shown number. The port then shows valid 0 in the next cycle. Active ends only through an active-clear write.
- R11: Processor port outputs are registered. A state change made at a clock edge appears on the ports one edge later. Read data is captured at the edge where reg_rd is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_cpu | input | CPU_W | Requesting processor number |
| reg_addr | input | 14 | Function (13:10) and index (9:0) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| ppi_line | input | NUM_CPU*16 | Private peripheral lines, 16 per processor |
| spi_line | input | NUM_IRQ-32 | Shared peripheral lines |
| cpu_ack | input | NUM_CPU | Acknowledge pulse per processor |
| cpu_valid | output | NUM_CPU | Interrupt presented per processor |
| cpu_id | output | NUM_CPU*10 | Presented interrupt number per processor |
| cpu_prio | output | NUM_CPU*8 | Presented priority per processor |

## Verification
A flag stored in the wrong slot or bank shows up as a wrong valid or number on a processor port exactly one edge after the state changes. It also shows up as a wrong bit on the next register read. A lost acknowledge, or a stuck active flag, leaves a port presenting the same number again, or going silent, on the cycle right after the pulse. Aliasing of out-of-range numbers is exposed by reading back the in-range neighbour that a truncated index would hit.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
  localparam int ID_W   = 10;
  localparam int PRIO_W = 8;
  localparam int FN_W   = 4;
  localparam int IDX_W  = 10;
  localparam int ADDR_W = FN_W + IDX_W;

  typedef enum logic [FN_W-1:0] {
    FN_EN_SET = 4'd0, FN_EN_CLR = 4'd1,
    FN_PD_SET = 4'd2, FN_PD_CLR = 4'd3,
    FN_AC_SET = 4'd4, FN_AC_CLR = 4'd5,
    FN_PRIO   = 4'd6, FN_TGT    = 4'd7,
    FN_CFG    = 4'd8, FN_SGI    = 4'd9
  } reg_fn_e;

  typedef enum logic [1:0] {
    SGI_LIST = 2'd0, SGI_OTHERS = 2'd1, SGI_SELF = 2'd2, SGI_NONE = 2'd3
  } sgi_mode_e;
endpackage

// File: rtl/irq_sgi_route.sv
module irq_sgi_route #(
  parameter int NUM_CPU = 4,
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic [1:0]         mode,
  input  logic [NUM_CPU-1:0] list,
  input  logic [CPU_W-1:0]   requester,
  output logic [NUM_CPU-1:0] targets
);
  import irq_dist_pkg::*;

  always_comb begin
    for (int c = 0; c < NUM_CPU; c++) begin
      case (sgi_mode_e'(mode))
        SGI_LIST:   targets[c] = list[c];
        SGI_OTHERS: targets[c] = (requester != CPU_W'(c));
        SGI_SELF:   targets[c] = (requester == CPU_W'(c));
        default:    targets[c] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NCAND  = 64,
  parameter int PRIO_W = 8,
  localparam int SEL_W = $clog2(NCAND)
) (
  input  logic [NCAND-1:0]        elig,
  input  logic [NCAND*PRIO_W-1:0] prio_flat,
  output logic                    found,
  output logic [SEL_W-1:0]        win,
  output logic [PRIO_W-1:0]       win_prio
);
  // Strict less-than keeps the lowest index on equal priority.
  always_comb begin
    found    = 1'b0;
    win      = '0;
    win_prio = '1;
    for (int i = 0; i < NCAND; i++) begin
      if (elig[i] && (!found || prio_flat[i*PRIO_W +: PRIO_W] < win_prio)) begin
        found    = 1'b1;
        win      = SEL_W'(i);
        win_prio = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irq_dist_top.sv
module irq_dist_top
  import irq_dist_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 4,
  localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int NUM_SPI = NUM_IRQ - 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       reg_wr,
  input  logic                       reg_rd,
  input  logic [CPU_W-1:0]           reg_cpu,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [31:0]                reg_wdata,
  output logic [31:0]                reg_rdata,
  input  logic [NUM_CPU*16-1:0]      ppi_line,
  input  logic [NUM_SPI-1:0]         spi_line,
  input  logic [NUM_CPU-1:0]         cpu_ack,
  output logic [NUM_CPU-1:0]         cpu_valid,
  output logic [NUM_CPU*ID_W-1:0]    cpu_id,
  output logic [NUM_CPU*PRIO_W-1:0]  cpu_prio
);
  localparam int PRIV   = NUM_CPU * 32;
  localparam int NSLOT  = PRIV + NUM_SPI;
  localparam int SEL_W  = $clog2(NUM_IRQ);

  // Slot layout: banked numbers 0..31 of each processor, then shared ones.
  function automatic int slot_id(int s);
    return (s < PRIV) ? (s % 32) : (s - PRIV + 32);
  endfunction
  function automatic int slot_owner(int s);
    return (s < PRIV) ? (s / 32) : 0;
  endfunction

  logic [NSLOT-1:0]   en_q, pd_q, ac_q, cfg_q, line_q;
  logic [NSLOT-1:0]   en_d, pd_d, ac_d, cfg_d;
  logic [NSLOT-1:0]   has_line, line_s, ack_hit;
  logic [PRIO_W-1:0]  prio_q [NSLOT];
  logic [PRIO_W-1:0]  prio_d [NSLOT];
  logic [NUM_CPU-1:0] tgt_q [NUM_SPI];
  logic [NUM_CPU-1:0] tgt_d [NUM_SPI];
  logic [NUM_CPU-1:0] sgi_tgt;
  logic [31:0]        rd_comb;
  reg_fn_e            fn;
  logic [IDX_W-1:0]   idx;

  assign fn  = reg_fn_e'(reg_addr[ADDR_W-1 -: FN_W]);
  assign idx = reg_addr[IDX_W-1:0];

  irq_sgi_route #(.NUM_CPU(NUM_CPU)) u_sgi (
    .mode(reg_wdata[25:24]), .list(reg_wdata[8 +: NUM_CPU]),
    .requester(reg_cpu), .targets(sgi_tgt)
  );

  // Line wiring per slot
  for (genvar s = 0; s < NSLOT; s++) begin : g_line
    if (s >= PRIV) begin : g_spi
      assign has_line[s] = 1'b1;
      assign line_s[s]   = spi_line[s-PRIV];
    end else if ((s % 32) >= 16) begin : g_ppi
      assign has_line[s] = 1'b1;
      assign line_s[s]   = ppi_line[(s/32)*16 + (s%32) - 16];
    end else begin : g_sgi
      assign has_line[s] = 1'b0;
      assign line_s[s]   = 1'b0;
    end
  end

  // Acknowledge decode: the number shown on a port, in that port's view
  always_comb begin
    ack_hit = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      if (cpu_ack[c] && cpu_valid[c]) begin
        for (int s = 0; s < NSLOT; s++) begin
          if (slot_id(s) == int'(cpu_id[c*ID_W +: ID_W]) &&
              (s >= PRIV || slot_owner(s) == c))
            ack_hit[s] = 1'b1;
        end
      end
    end
  end

  // Next state
  always_comb begin
    en_d = en_q; pd_d = pd_q; ac_d = ac_q; cfg_d = cfg_q;
    prio_d = prio_q; tgt_d = tgt_q;
    for (int s = 0; s < NSLOT; s++) begin
      automatic int   id     = slot_id(s);
      automatic logic vis    = (s >= PRIV) || (slot_owner(s) == int'(reg_cpu));
      automatic logic bit_hit = reg_wr && vis && (id / 32 == int'(idx)) && reg_wdata[id % 32];
      automatic logic id_hit = reg_wr && vis && (id == int'(idx));
      if (has_line[s] && !cfg_q[s] && !ac_q[s]) pd_d[s] = line_s[s];
      if (ack_hit[s] && pd_q[s] && !ac_q[s]) begin
        pd_d[s] = 1'b0;
        ac_d[s] = 1'b1;
      end
      if (has_line[s] && cfg_q[s] && line_s[s] && !line_q[s]) pd_d[s] = 1'b1;
      if (reg_wr && fn == FN_SGI && s < PRIV && id < 16 &&
          id == int'(reg_wdata[3:0]) && sgi_tgt[slot_owner(s)]) pd_d[s] = 1'b1;
      if (bit_hit) begin
        case (fn)
          FN_EN_SET: en_d[s] = 1'b1;
          FN_EN_CLR: en_d[s] = 1'b0;
          FN_PD_SET: pd_d[s] = 1'b1;
          FN_PD_CLR: pd_d[s] = 1'b0;
          FN_AC_SET: ac_d[s] = 1'b1;
          FN_AC_CLR: ac_d[s] = 1'b0;
          default: ;
        endcase
      end
      if (id_hit && fn == FN_PRIO) prio_d[s] = reg_wdata[PRIO_W-1:0];
      if (id_hit && fn == FN_CFG && has_line[s]) cfg_d[s] = reg_wdata[0];
    end
    for (int j = 0; j < NUM_SPI; j++) begin
      if (reg_wr && fn == FN_TGT && int'(idx) == j + 32) tgt_d[j] = reg_wdata[NUM_CPU-1:0];
    end
  end

  // Read mux
  always_comb begin
    rd_comb = '0;
    for (int s = 0; s < NSLOT; s++) begin
      automatic int   id  = slot_id(s);
      automatic logic vis = (s >= PRIV) || (slot_owner(s) == int'(reg_cpu));
      if (vis && id / 32 == int'(idx)) begin
        case (fn)
          FN_EN_SET, FN_EN_CLR: rd_comb[id % 32] = en_q[s];
          FN_PD_SET, FN_PD_CLR: rd_comb[id % 32] = pd_q[s];
          FN_AC_SET, FN_AC_CLR: rd_comb[id % 32] = ac_q[s];
          default: ;
        endcase
      end
      if (vis && id == int'(idx)) begin
        if (fn == FN_PRIO) rd_comb[PRIO_W-1:0] = prio_q[s];
        if (fn == FN_CFG)  rd_comb[0] = cfg_q[s];
      end
    end
    for (int j = 0; j < NUM_SPI; j++) begin
      if (fn == FN_TGT && int'(idx) == j + 32) rd_comb[NUM_CPU-1:0] = tgt_q[j];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0; pd_q <= '0; ac_q <= '0; cfg_q <= '1; line_q <= '0;
      reg_rdata <= '0;
      for (int s = 0; s < NSLOT; s++) prio_q[s] <= '0;
      for (int j = 0; j < NUM_SPI; j++) tgt_q[j] <= '0;
    end else begin
      en_q <= en_d; pd_q <= pd_d; ac_q <= ac_d; cfg_q <= cfg_d; line_q <= line_s;
      prio_q <= prio_d;
      tgt_q  <= tgt_d;
      if (reg_rd) reg_rdata <= rd_comb;
    end
  end

  // One arbiter per processor port
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_IRQ-1:0]        elig;
    logic [NUM_IRQ*PRIO_W-1:0] pflat;
    logic                      found;
    logic [SEL_W-1:0]          win;
    logic [PRIO_W-1:0]         wprio;
    logic                      v_q;
    logic [ID_W-1:0]           id_q;
    logic [PRIO_W-1:0]         p_q;

    always_comb begin
      for (int i = 0; i < NUM_IRQ; i++) begin
        automatic int s = (i < 32) ? (c * 32 + i) : (PRIV + i - 32);
        elig[i] = en_q[s] && pd_q[s] && !ac_q[s] &&
                  ((i < 32) || tgt_q[(i < 32) ? 0 : i - 32][c]);
        pflat[i*PRIO_W +: PRIO_W] = prio_q[s];
      end
    end

    irq_arbiter #(.NCAND(NUM_IRQ), .PRIO_W(PRIO_W)) u_arb (
      .elig(elig), .prio_flat(pflat), .found(found), .win(win), .win_prio(wprio)
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= 1'b0; id_q <= '0; p_q <= '0;
      end else begin
        v_q  <= found && !(cpu_ack[c] && v_q);
        id_q <= ID_W'(win);
        p_q  <= wprio;
      end
    end

    assign cpu_valid[c]                 = v_q;
    assign cpu_id[c*ID_W +: ID_W]       = id_q;
    assign cpu_prio[c*PRIO_W +: PRIO_W] = p_q;
  end
endmodule

// File: rtl/irq_dist_chk.sv
module irq_dist_chk
  import irq_dist_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 4,
  localparam int NSLOT = NUM_CPU * 32 + NUM_IRQ - 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    reg_wr,
  input logic [NUM_CPU-1:0]      cpu_ack,
  input logic [NUM_CPU-1:0]      cpu_valid,
  input logic [NUM_CPU*ID_W-1:0] cpu_id,
  input logic [NSLOT-1:0]        en_q,
  input logic [NSLOT-1:0]        pd_q,
  input logic [NSLOT-1:0]        ac_q
);
  function automatic int slot_of(int c, int id);
    if (id >= NUM_IRQ) return 0;
    return (id < 32) ? (c * 32 + id) : (NUM_CPU * 32 + id - 32);
  endfunction

  logic [NSLOT-1:0] en_p, pd_p, ac_p;
  always_ff @(posedge clk) begin
    if (rst) begin
      en_p <= '0; pd_p <= '0; ac_p <= '0;
    end else begin
      en_p <= en_q; pd_p <= pd_q; ac_p <= ac_q;
    end
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
    int sl, sl_p;
    assign sl = slot_of(c, int'(cpu_id[c*ID_W +: ID_W]));
    always_ff @(posedge clk) sl_p <= sl;

    // R3
    id_range_chk: assert property (@(posedge clk) disable iff (rst)
      cpu_valid[c] |-> (int'(cpu_id[c*ID_W +: ID_W]) < NUM_IRQ));

    // R2
    enabled_only_chk: assert property (@(posedge clk) disable iff (rst)
      cpu_valid[c] |-> en_p[sl]);

    // R10
    pending_idle_chk: assert property (@(posedge clk) disable iff (rst)
      cpu_valid[c] |-> (pd_p[sl] && !ac_p[sl]));

    // R10
    ack_to_active_chk: assert property (@(posedge clk) disable iff (rst)
      (cpu_valid[c] && cpu_ack[c] && !reg_wr && pd_q[sl] && !ac_q[sl]) |=> (ac_q[sl_p] && !pd_q[sl_p]));
  end
endmodule

bind irq_dist_top irq_dist_chk #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .cpu_ack(cpu_ack),
  .cpu_valid(cpu_valid), .cpu_id(cpu_id),
  .en_q(en_q), .pd_q(pd_q), .ac_q(ac_q)
);

// File: tb/tb_irq_dist_top.sv
module tb_irq_dist_top;
  localparam int NUM_IRQ = 64;
  localparam int NUM_CPU = 4;
  localparam int NUM_SPI = NUM_IRQ - 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_cpu = '0;
  logic [13:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NUM_CPU*16-1:0] ppi_line = '0;
  logic [NUM_SPI-1:0]    spi_line = '0;
  logic [NUM_CPU-1:0]    cpu_ack = '0;
  logic [NUM_CPU-1:0]    cpu_valid;
  logic [NUM_CPU*10-1:0] cpu_id;
  logic [NUM_CPU*8-1:0]  cpu_prio;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  irq_dist_top #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_cpu(reg_cpu),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ppi_line(ppi_line), .spi_line(spi_line), .cpu_ack(cpu_ack),
    .cpu_valid(cpu_valid), .cpu_id(cpu_id), .cpu_prio(cpu_prio)
  );

  // Function codes as stated in R5
  localparam logic [3:0] EN_S = 4'd0, EN_C = 4'd1, PD_S = 4'd2, PD_C = 4'd3,
                         AC_S = 4'd4, AC_C = 4'd5, PRI = 4'd6, TGT = 4'd7,
                         CFG = 4'd8, SGI = 4'd9;

  typedef struct packed {
    logic        wr;
    logic [3:0]  fn;
    logic [9:0]  idx;
    logic [31:0] data;
    logic [7:0]  req;
  } vec_t;

  // Register-port vectors, requester 0; read rows hold expected data.
  localparam int NV = 34;
  localparam vec_t VECS [NV] = '{
    '{1'b1, EN_S, 10'd1,  32'h0000_00F0, 8'd5},  // R5 set 36..39
    '{1'b0, EN_S, 10'd1,  32'h0000_00F0, 8'd5},
    '{1'b1, EN_C, 10'd1,  32'h0000_0030, 8'd5},
    '{1'b0, EN_C, 10'd1,  32'h0000_00C0, 8'd5},
    '{1'b1, EN_S, 10'd1,  32'h0000_0000, 8'd5},  // R5 zero writes
    '{1'b1, EN_C, 10'd1,  32'h0000_0000, 8'd5},
    '{1'b0, EN_S, 10'd1,  32'h0000_00C0, 8'd5},
    '{1'b1, PRI,  10'd40, 32'h0000_005A, 8'd5},
    '{1'b0, PRI,  10'd40, 32'h0000_005A, 8'd5},
    '{1'b1, PRI,  10'd96, 32'h0000_0022, 8'd9},  // R9 out of range
    '{1'b0, PRI,  10'd32, 32'h0000_0000, 8'd9},
    '{1'b1, EN_S, 10'd2,  32'hFFFF_FFFF, 8'd9},
    '{1'b0, EN_S, 10'd2,  32'h0000_0000, 8'd9},
    '{1'b0, EN_S, 10'd1,  32'h0000_00C0, 8'd9},
    '{1'b1, PD_S, 10'd0,  32'h0000_0008, 8'd5},
    '{1'b0, PD_S, 10'd0,  32'h0000_0008, 8'd5},
    '{1'b1, PD_C, 10'd0,  32'h0000_0008, 8'd5},
    '{1'b0, PD_C, 10'd0,  32'h0000_0000, 8'd5},
    '{1'b1, AC_S, 10'd1,  32'h0000_0004, 8'd5},
    '{1'b0, AC_S, 10'd1,  32'h0000_0004, 8'd5},
    '{1'b1, AC_C, 10'd1,  32'h0000_0004, 8'd5},
    '{1'b0, AC_C, 10'd1,  32'h0000_0000, 8'd5},
    '{1'b1, CFG,  10'd40, 32'h0000_0000, 8'd7},
    '{1'b0, CFG,  10'd40, 32'h0000_0000, 8'd7},
    '{1'b1, CFG,  10'd2,  32'h0000_0000, 8'd7},  // R7 no line, stays edge
    '{1'b0, CFG,  10'd2,  32'h0000_0001, 8'd7},
    '{1'b1, TGT,  10'd40, 32'h0000_0005, 8'd3},
    '{1'b0, TGT,  10'd40, 32'h0000_0005, 8'd3},
    '{1'b1, TGT,  10'd20, 32'h0000_000F, 8'd3},  // R3 private target ignored
    '{1'b0, TGT,  10'd20, 32'h0000_0000, 8'd3},
    '{1'b1, EN_C, 10'd1,  32'h0000_00C0, 8'd5},
    '{1'b0, EN_S, 10'd1,  32'h0000_0000, 8'd5},
    '{1'b1, CFG,  10'd40, 32'h0000_0001, 8'd6},
    '{1'b0, CFG,  10'd40, 32'h0000_0001, 8'd6}
  };

  task automatic wr(input int cpu, input logic [3:0] fn, input int idx, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_cpu = 2'(cpu); reg_addr = {fn, 10'(idx)}; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int cpu, input logic [3:0] fn, input int idx,
                    input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_cpu = 2'(cpu); reg_addr = {fn, 10'(idx)};
    @(negedge clk);
    reg_rd = 1'b0;
    checks++;
    if (reg_rdata !== exp) begin
      fails++;
      $display("FAIL %s read fn=%0d idx=%0d actual=%h expected=%h", tag, fn, idx, reg_rdata, exp);
    end
  endtask

  task automatic ack(input int c);
    @(negedge clk);
    cpu_ack[c] = 1'b1;
    @(negedge clk);
    cpu_ack[c] = 1'b0;
  endtask

  task automatic chk_out(input int c, input int waits, input logic ev,
                         input int eid, input int ep, input string tag);
    logic ok;
    repeat (waits) @(negedge clk);
    checks++;
    ok = (cpu_valid[c] === ev) &&
         (!ev || (int'(cpu_id[c*10 +: 10]) == eid && int'(cpu_prio[c*8 +: 8]) == ep));
    if (!ok) begin
      fails++;
      $display("FAIL %s cpu%0d actual valid=%b id=%0d prio=%0d expected valid=%b id=%0d prio=%0d",
               tag, c, cpu_valid[c], cpu_id[c*10 +: 10], cpu_prio[c*8 +: 8], ev, eid, ep);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    for (int c = 0; c < NUM_CPU; c++) chk_out(c, 0, 1'b0, 0, 0, "R1");
    rd(0, EN_S, 1, 32'h0, "R1");
    rd(0, PRI, 40, 32'h0, "R1");
    rd(0, CFG, 40, 32'h1, "R1");

    for (int v = 0; v < NV; v++) begin
      if (VECS[v].wr) wr(0, VECS[v].fn, int'(VECS[v].idx), VECS[v].data);
      else rd(0, VECS[v].fn, int'(VECS[v].idx), VECS[v].data, $sformatf("R%0d", VECS[v].req));
    end

    // R3 R4 targeting and priority
    wr(0, TGT, 40, 32'h2); wr(0, TGT, 41, 32'h2);
    wr(0, PRI, 40, 32'h20); wr(0, PRI, 41, 32'h10);
    wr(0, EN_S, 1, 32'h300);
    wr(0, PD_S, 1, 32'h300);
    chk_out(1, 0, 1'b0, 0, 0, "R11");          // one edge later, not yet
    chk_out(1, 1, 1'b1, 41, 'h10, "R4");
    chk_out(0, 0, 1'b0, 0, 0, "R3");
    wr(0, PRI, 41, 32'h20);
    chk_out(1, 2, 1'b1, 40, 'h20, "R4 tie");
    // R10 acknowledge
    ack(1);
    chk_out(1, 0, 1'b0, 0, 0, "R10 drop");
    chk_out(1, 1, 1'b1, 41, 'h20, "R10");
    rd(0, AC_S, 1, 32'h100, "R10");
    rd(0, PD_S, 1, 32'h200, "R10");
    // R2 disabled interrupt
    wr(0, EN_C, 1, 32'h200);
    chk_out(1, 2, 1'b0, 0, 0, "R2");
    rd(0, PD_S, 1, 32'h200, "R2");
    wr(0, PD_C, 1, 32'h200); wr(0, AC_C, 1, 32'h100);

    // R6 edge mode on 42
    wr(0, TGT, 42, 32'h4); wr(0, PRI, 42, 32'h30); wr(0, EN_S, 1, 32'h400);
    @(negedge clk); spi_line[10] = 1'b1;
    chk_out(2, 2, 1'b1, 42, 'h30, "R6");
    @(negedge clk); spi_line[10] = 1'b0;
    chk_out(2, 2, 1'b1, 42, 'h30, "R6 held");
    ack(2);
    wr(0, AC_C, 1, 32'h400);
    chk_out(2, 2, 1'b0, 0, 0, "R6 no repend");

    // R7 level mode on 43
    wr(0, CFG, 43, 32'h0); wr(0, TGT, 43, 32'h8); wr(0, EN_S, 1, 32'h800);
    @(negedge clk); spi_line[11] = 1'b1;
    chk_out(3, 2, 1'b1, 43, 0, "R7");
    @(negedge clk); spi_line[11] = 1'b0;
    chk_out(3, 2, 1'b0, 0, 0, "R7 follow");
    @(negedge clk); spi_line[11] = 1'b1;
    chk_out(3, 2, 1'b1, 43, 0, "R7");
    ack(3);
    chk_out(3, 1, 1'b0, 0, 0, "R7 active");
    wr(0, AC_C, 1, 32'h800);
    chk_out(3, 2, 1'b1, 43, 0, "R7 reassert");
    @(negedge clk); spi_line[11] = 1'b0;
    chk_out(3, 2, 1'b0, 0, 0, "R7");

    // R3 private line of processor 2, number 20
    wr(2, EN_S, 0, 32'h0010_0000);
    @(negedge clk); ppi_line[2*16+4] = 1'b1;
    chk_out(2, 2, 1'b1, 20, 0, "R3 private");
    chk_out(0, 0, 1'b0, 0, 0, "R3 private");
    rd(0, EN_S, 0, 32'h0, "R3 bank");
    ack(2);
    @(negedge clk); ppi_line[2*16+4] = 1'b0;
    wr(2, AC_C, 0, 32'h0010_0000);

    // R8 software interrupts, number 5, requester 1
    wr(1, SGI, 0, 32'h0000_0505);
    for (int c = 0; c < NUM_CPU; c++)
      rd(c, PD_S, 0, (c == 0 || c == 2) ? 32'h20 : 32'h0, "R8 list");
    for (int c = 0; c < NUM_CPU; c++) wr(c, PD_C, 0, 32'h20);
    wr(1, SGI, 0, 32'h0100_0005);
    for (int c = 0; c < NUM_CPU; c++)
      rd(c, PD_S, 0, (c != 1) ? 32'h20 : 32'h0, "R8 others");
    for (int c = 0; c < NUM_CPU; c++) wr(c, PD_C, 0, 32'h20);
    wr(1, SGI, 0, 32'h0200_0005);
    for (int c = 0; c < NUM_CPU; c++)
      rd(c, PD_S, 0, (c == 1) ? 32'h20 : 32'h0, "R8 self");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule